// File: doc/BRIEF.md
# Multi-Window Pass-Through Request Decoder

This block sits between a simplified host target port and user logic on the local side. Each host access (address, space type, direction, byte enables, burst flag, write data) is compared against a set of configurable address windows. Every window has its own enable, base address, power-of-two size, data width and space type (memory or I/O). When a window claims the access, the block presents a decoded request to user logic. The request carries the direction, byte lanes, address, window index, window width code and a burst-or-single flag. The block then waits for the local ready handshake.

If user logic answers in the same cycle, the host beat completes at once, so a burst can move one beat per clock. If the local side stays silent for a configurable number of cycles, the host access is ended with a retry. The request stays posted to user logic until it completes. The finished result is held in a one-entry buffer, and a later repeat of the same access is answered from that buffer without touching user logic again. An access that no window claims is flagged as a miss.

Top module: `pt_region_decoder`

## Requirements
- R1: A window i claims an access when it is enabled and the address bits above its size exponent equal those of its base; the size exponent is taken from `cfg_size` and clamped to 29 (512 MB).
- R2: An access claims only windows whose space bit matches `host_io` (1 = I/O, 0 = memory); a window whose `cfg_en` bit is 0 claims nothing.
- R3: When several windows claim one access, the lowest window index wins.
- R4: An access that no window claims raises `host_miss` in the same cycle and produces no fresh local request.
- R5: A claimed access drives `loc_req` in the same cycle with `loc_write`, `loc_addr`, `loc_be`, `loc_wdata` and `loc_burst` taken from the host, `loc_region` set to the winning index, and `loc_width` set to that window's width code (0 = 8 bit, 1 = 16 bit, 2 = 32 bit).
- R6: When `loc_rdy` is high in the cycle of a claimed fresh access, `host_ack` rises in that cycle and `host_rdata` equals `loc_rdata`, so back-to-back burst beats each finish in one clock.
- R7: A fresh claimed access that sees no `loc_rdy` gets `host_retry` in its TIMEOUT-th cycle (cycle TIMEOUT-1, counting the first cycle as 0) and no response earlier.
- R8: After a retry, the same request (address, direction, write data) stays on the local side with `loc_burst` low until `loc_rdy`; while it is outstanding, every claimed host access gets `host_retry` in its first cycle.
- R9: A completed retried transfer is kept; the next claimed host access with the same address and direction gets `host_ack` in its first cycle with no local request, a read returning the data captured from `loc_rdata`; the kept entry is then used up.
- R10: At most one of `host_ack`, `host_retry`, `host_miss` is high in any cycle, and none is high while `host_valid` is low.
- R11: After reset, with the host idle, `loc_req`, `host_ack`, `host_retry` and `host_miss` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | NREG | Per-window enable |
| cfg_io | input | NREG | Per-window space: 1 = I/O, 0 = memory |
| cfg_base | input | NREG*32 | Per-window base address, window 0 in the low bits |
| cfg_size | input | NREG*5 | Per-window size exponent (bytes = 2^n, clamped to 29) |
| cfg_width | input | NREG*2 | Per-window width code: 0 = 8, 1 = 16, 2 = 32 bit |
| host_valid | input | 1 | Host access present, held until a response |
| host_addr | input | 32 | Host byte address |
| host_io | input | 1 | Host access space: 1 = I/O, 0 = memory |
| host_write | input | 1 | 1 = write, 0 = read |
| host_be | input | 4 | Host byte enables |
| host_burst | input | 1 | Beat belongs to a burst |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | Beat completed |
| host_retry | output | 1 | Access ended, host must retry |
| host_miss | output | 1 | No window claims the access |
| host_rdata | output | 32 | Read data returned with `host_ack` |
| loc_req | output | 1 | Request to user logic |
| loc_write | output | 1 | Request direction |
| loc_addr | output | 32 | Request address |
| loc_be | output | 4 | Request byte lanes |
| loc_region | output | 2 | Winning window index |
| loc_width | output | 2 | Width code of the winning window |
| loc_burst | output | 1 | Request is a burst beat |
| loc_wdata | output | 32 | Write data to user logic |
| loc_rdy | input | 1 | User logic completes the request this cycle |
| loc_rdata | input | 32 | Read data from user logic |

## Verification
The bench builds the block with four windows and a TIMEOUT of 4 cycles. The short timeout puts the retry boundary, the outstanding-request phase and the answer from the kept entry within a few cycles of each access. Four windows allow a 4 KB memory window nested inside a 64 KB one to show the priority, an I/O window to show the space check, and a 512 MB window whose top and first outside addresses probe the size limit.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int BEW    = DW / 8;
    localparam int SZW    = 5;
    localparam int MAXLOG = 29;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2
    } width_e;
endpackage

// File: rtl/pt_window_match.sv
module pt_window_match #(
    parameter int AW     = 32,
    parameter int SZW    = 5,
    parameter int MAXLOG = 29
) (
    input  logic           en,
    input  logic           is_io,
    input  logic [AW-1:0]  base,
    input  logic [SZW-1:0] size_log2,
    input  logic [AW-1:0]  addr,
    input  logic           acc_io,
    output logic           hit
);
    logic [SZW-1:0] lg;
    logic [AW-1:0]  mask;

    always_comb begin
        lg   = (size_log2 > SZW'(MAXLOG)) ? SZW'(MAXLOG) : size_log2;
        mask = ~((AW'(1) << lg) - AW'(1));
        hit  = en && (is_io == acc_io) && (((addr ^ base) & mask) == '0);
    end
endmodule

// File: rtl/pt_prio_sel.sv
module pt_prio_sel #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pt_region_decoder.sv
module pt_region_decoder
    import pt_pkg::*;
#(
    parameter int NREG    = 4,
    parameter int TIMEOUT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREG-1:0]      cfg_en,
    input  logic [NREG-1:0]      cfg_io,
    input  logic [NREG*AW-1:0]   cfg_base,
    input  logic [NREG*SZW-1:0]  cfg_size,
    input  logic [NREG*2-1:0]    cfg_width,
    input  logic                 host_valid,
    input  logic [AW-1:0]        host_addr,
    input  logic                 host_io,
    input  logic                 host_write,
    input  logic [BEW-1:0]       host_be,
    input  logic                 host_burst,
    input  logic [DW-1:0]        host_wdata,
    output logic                 host_ack,
    output logic                 host_retry,
    output logic                 host_miss,
    output logic [DW-1:0]        host_rdata,
    output logic                 loc_req,
    output logic                 loc_write,
    output logic [AW-1:0]        loc_addr,
    output logic [BEW-1:0]       loc_be,
    output logic [(NREG>1 ? $clog2(NREG) : 1)-1:0] loc_region,
    output logic [1:0]           loc_width,
    output logic                 loc_burst,
    output logic [DW-1:0]        loc_wdata,
    input  logic                 loc_rdy,
    input  logic [DW-1:0]        loc_rdata
);
    localparam int RIW   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic            pend_v;
        logic [AW-1:0]   pend_addr;
        logic            pend_wr;
        logic [BEW-1:0]  pend_be;
        logic [RIW-1:0]  pend_reg;
        logic [1:0]      pend_wid;
        logic [DW-1:0]   pend_wd;
        logic            keep_v;
        logic [AW-1:0]   keep_addr;
        logic            keep_wr;
        logic [DW-1:0]   keep_data;
        logic [CNT_W-1:0] wait_cnt;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0] win_hit;
    logic            hit_any;
    logic [RIW-1:0]  sel_idx;
    logic [1:0]      sel_wid;
    logic            keep_match;
    logic            fresh;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        pt_window_match #(.AW(AW), .SZW(SZW), .MAXLOG(MAXLOG)) u_match (
            .en        (cfg_en[g]),
            .is_io     (cfg_io[g]),
            .base      (cfg_base[g*AW +: AW]),
            .size_log2 (cfg_size[g*SZW +: SZW]),
            .addr      (host_addr),
            .acc_io    (host_io),
            .hit       (win_hit[g])
        );
    end

    pt_prio_sel #(.N(NREG), .IW(RIW)) u_prio (
        .hits (win_hit),
        .any  (hit_any),
        .idx  (sel_idx)
    );

    always_comb begin
        st_d    = st_q;
        sel_wid = cfg_width[sel_idx*2 +: 2];

        keep_match = st_q.keep_v && host_valid && hit_any &&
                     (host_addr == st_q.keep_addr) && (host_write == st_q.keep_wr);
        fresh      = host_valid && hit_any && !st_q.pend_v && !keep_match;

        // host side responses
        host_miss  = host_valid && !hit_any;
        host_ack   = keep_match || (fresh && loc_rdy);
        host_retry = host_valid && hit_any && !keep_match &&
                     (st_q.pend_v || (!loc_rdy && st_q.wait_cnt == LIM));
        host_rdata = keep_match ? st_q.keep_data : loc_rdata;

        // local side request
        loc_req = st_q.pend_v || fresh;
        if (st_q.pend_v) begin
            loc_write  = st_q.pend_wr;
            loc_addr   = st_q.pend_addr;
            loc_be     = st_q.pend_be;
            loc_region = st_q.pend_reg;
            loc_width  = st_q.pend_wid;
            loc_burst  = 1'b0;
            loc_wdata  = st_q.pend_wd;
        end else begin
            loc_write  = host_write;
            loc_addr   = host_addr;
            loc_be     = host_be;
            loc_region = sel_idx;
            loc_width  = sel_wid;
            loc_burst  = host_burst;
            loc_wdata  = host_wdata;
        end

        // wait counter for a fresh access
        st_d.wait_cnt = (fresh && !loc_rdy && !host_retry) ? st_q.wait_cnt + 1'b1 : '0;

        // outstanding request finishes into the keep entry
        if (st_q.pend_v && loc_rdy) begin
            st_d.pend_v    = 1'b0;
            st_d.keep_v    = 1'b1;
            st_d.keep_addr = st_q.pend_addr;
            st_d.keep_wr   = st_q.pend_wr;
            st_d.keep_data = st_q.pend_wr ? st_q.pend_wd : loc_rdata;
        end

        // fresh access timed out: post it to the local side
        if (fresh && host_retry) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_addr = host_addr;
            st_d.pend_wr   = host_write;
            st_d.pend_be   = host_be;
            st_d.pend_reg  = sel_idx;
            st_d.pend_wid  = sel_wid;
            st_d.pend_wd   = host_wdata;
            st_d.keep_v    = 1'b0;
        end

        // kept result used up, or superseded by a direct completion
        if (keep_match || (fresh && loc_rdy)) st_d.keep_v = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pt_region_decoder_chk.sv
module pt_region_decoder_chk #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int TIMEOUT = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_valid,
    input logic          host_ack,
    input logic          host_retry,
    input logic          host_miss,
    input logic          loc_req,
    input logic          loc_rdy,
    input logic          loc_write,
    input logic [AW-1:0] loc_addr,
    input logic [DW-1:0] loc_wdata
);
    logic [31:0] wait_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_len <= '0;
        else if (host_valid && !(host_ack || host_retry || host_miss))
            wait_len <= (wait_len < 32'(TIMEOUT)) ? wait_len + 1 : wait_len;
        else wait_len <= '0;
    end

    // R10
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_ack, host_retry, host_miss}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |-> !(host_ack || host_retry || host_miss));

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_retry && !loc_rdy) |=> loc_req);

    // R8
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_retry && !loc_rdy) |=> ($stable(loc_addr) && $stable(loc_write) && $stable(loc_wdata)));

    // R7
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_len < 32'(TIMEOUT));
endmodule

bind pt_region_decoder pt_region_decoder_chk #(
    .AW(pt_pkg::AW), .DW(pt_pkg::DW), .TIMEOUT(TIMEOUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ack(host_ack),
    .host_retry(host_retry), .host_miss(host_miss), .loc_req(loc_req),
    .loc_rdy(loc_rdy), .loc_write(loc_write), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata)
);

// File: tb/pt_region_decoder_tb.sv
`timescale 1ns/1ps
module pt_region_decoder_tb;
    localparam int NREG = 4;
    localparam int TO   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NREG-1:0]    cfg_en, cfg_io;
    logic [NREG*32-1:0] cfg_base;
    logic [NREG*5-1:0]  cfg_size;
    logic [NREG*2-1:0]  cfg_width;
    logic        host_valid = 0, host_io = 0, host_write = 0, host_burst = 0;
    logic [31:0] host_addr = 0, host_wdata = 0;
    logic [3:0]  host_be = 0;
    logic        host_ack, host_retry, host_miss;
    logic [31:0] host_rdata;
    logic        loc_req, loc_write, loc_burst;
    logic [31:0] loc_addr, loc_wdata;
    logic [3:0]  loc_be;
    logic [1:0]  loc_region, loc_width;
    logic        loc_rdy = 0;
    logic [31:0] loc_rdata = 0;

    pt_region_decoder #(.NREG(NREG), .TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_io(cfg_io),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_width(cfg_width),
        .host_valid(host_valid), .host_addr(host_addr), .host_io(host_io),
        .host_write(host_write), .host_be(host_be), .host_burst(host_burst),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_retry(host_retry),
        .host_miss(host_miss), .host_rdata(host_rdata), .loc_req(loc_req),
        .loc_write(loc_write), .loc_addr(loc_addr), .loc_be(loc_be),
        .loc_region(loc_region), .loc_width(loc_width), .loc_burst(loc_burst),
        .loc_wdata(loc_wdata), .loc_rdy(loc_rdy), .loc_rdata(loc_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] a, input logic io,
                         input logic wr, input logic [3:0] be, input logic [31:0] wd);
        host_valid = v; host_addr = a; host_io = io;
        host_write = wr; host_be = be; host_wdata = wd;
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        io;
        logic        wr;
        logic [3:0]  be;
        logic        miss;
        logic [1:0]  rgn;
        logic [1:0]  wid;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{32'h1000_0010, 1'b0, 1'b0, 4'hF, 1'b0, 2'd0, 2'd2, 4'd3},  // R3 nested: window 0 wins
        '{32'h1000_2000, 1'b0, 1'b1, 4'h3, 1'b0, 2'd1, 2'd1, 4'd5},  // R5 outer window, 16 bit
        '{32'h1000_0FFC, 1'b0, 1'b1, 4'h8, 1'b0, 2'd0, 2'd2, 4'd1},  // R1 top of 4 KB
        '{32'h1001_0000, 1'b0, 1'b0, 4'hF, 1'b1, 2'd0, 2'd0, 4'd4},  // R4 past 64 KB
        '{32'h0000_0404, 1'b1, 1'b0, 4'h1, 1'b0, 2'd2, 2'd0, 4'd5},  // R5 I/O, 8 bit
        '{32'h0000_0404, 1'b0, 1'b0, 4'h1, 1'b1, 2'd0, 2'd0, 4'd2},  // R2 wrong space
        '{32'h1000_0010, 1'b1, 1'b0, 4'hF, 1'b1, 2'd0, 2'd0, 4'd2},  // R2 wrong space
        '{32'h5FFF_FFFC, 1'b0, 1'b0, 4'hC, 1'b0, 2'd3, 2'd2, 4'd1},  // R1 top of 512 MB
        '{32'h6000_0000, 1'b0, 1'b0, 4'hF, 1'b1, 2'd0, 2'd0, 4'd1},  // R1 just past 512 MB
        '{32'h4000_0000, 1'b0, 1'b1, 4'hF, 1'b0, 2'd3, 2'd2, 4'd1}   // R1 base of 512 MB
    };

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        string rq;
        cfg_en    = 4'b1111;
        cfg_io    = 4'b0100;
        cfg_base  = {32'h4000_0000, 32'h0000_0400, 32'h1000_0000, 32'h1000_0000};
        cfg_size  = {5'd29, 5'd8, 5'd16, 5'd12};
        cfg_width = {2'd2, 2'd0, 2'd1, 2'd2};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        expect_eq("R11", "loc_req", 32'(loc_req), 0);
        expect_eq("R11", "responses", 32'({host_ack, host_retry, host_miss}), 0);

        // table walk, user logic always ready
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            rq = $sformatf("R%0d", VECS[i].rq);
            drive(1'b1, VECS[i].addr, VECS[i].io, VECS[i].wr, VECS[i].be, 32'hA500_0000 + 32'(i));
            loc_rdy = 1'b1; loc_rdata = 32'h7700_0000 + 32'(i);
            @(negedge clk);
            if (VECS[i].miss) begin
                expect_eq(rq, "host_miss", 32'(host_miss), 1);
                expect_eq(rq, "loc_req on miss", 32'(loc_req), 0);
                expect_eq(rq, "host_ack on miss", 32'(host_ack), 0);
            end else begin
                expect_eq(rq, "host_ack", 32'(host_ack), 1);
                expect_eq(rq, "loc_region", 32'(loc_region), 32'(VECS[i].rgn));
                expect_eq(rq, "loc_width", 32'(loc_width), 32'(VECS[i].wid));
                expect_eq(rq, "loc_be", 32'(loc_be), 32'(VECS[i].be));
                expect_eq(rq, "loc_write", 32'(loc_write), 32'(VECS[i].wr));
                expect_eq(rq, "loc_addr", loc_addr, VECS[i].addr);
                expect_eq(rq, "loc_wdata", loc_wdata, 32'hA500_0000 + 32'(i));
            end
        end

        // R6 burst: one beat per clock
        for (int b = 0; b < 3; b++) begin
            @(posedge clk); #1;
            drive(1'b1, 32'h1000_0100 + 32'(4 * b), 1'b0, 1'b0, 4'hF, 0);
            host_burst = 1'b1; loc_rdy = 1'b1; loc_rdata = 32'hB0B0_0000 + 32'(b);
            @(negedge clk);
            expect_eq("R6", "burst ack", 32'(host_ack), 1);
            expect_eq("R6", "burst rdata", host_rdata, 32'hB0B0_0000 + 32'(b));
            expect_eq("R5", "loc_burst", 32'(loc_burst), 1);
        end
        @(posedge clk); #1;
        host_valid = 1'b0; host_burst = 1'b0; loc_rdy = 1'b0;

        // R7 read timeout: retry only in cycle TO-1
        @(posedge clk); #1;
        drive(1'b1, 32'h1000_0020, 1'b0, 1'b0, 4'hF, 32'h1111_2222);
        for (int k = 0; k < TO; k++) begin
            @(negedge clk);
            expect_eq("R7", $sformatf("retry in cycle %0d", k), 32'(host_retry), (k == TO - 1) ? 1 : 0);
            expect_eq("R7", "no ack while waiting", 32'(host_ack), 0);
        end
        @(posedge clk); #1;
        host_valid = 1'b0;
        @(negedge clk);
        // R8 request stays posted
        expect_eq("R8", "loc_req held", 32'(loc_req), 1);
        expect_eq("R8", "loc_addr held", loc_addr, 32'h1000_0020);
        expect_eq("R8", "loc_burst low", 32'(loc_burst), 0);
        // R8 other access while outstanding: immediate retry
        @(posedge clk); #1;
        drive(1'b1, 32'h1000_0030, 1'b0, 1'b0, 4'hF, 0);
        @(negedge clk);
        expect_eq("R8", "retry while outstanding", 32'(host_retry), 1);
        expect_eq("R8", "loc_addr still posted", loc_addr, 32'h1000_0020);
        @(posedge clk); #1;
        host_valid = 1'b0; loc_rdy = 1'b1; loc_rdata = 32'hCAFE_0001;
        @(posedge clk); #1;
        loc_rdy = 1'b0; loc_rdata = 32'h0;
        @(negedge clk);
        expect_eq("R8", "loc_req drops after ready", 32'(loc_req), 0);
        // R9 repeat read answered from kept entry
        @(posedge clk); #1;
        drive(1'b1, 32'h1000_0020, 1'b0, 1'b0, 4'hF, 0);
        @(negedge clk);
        expect_eq("R9", "ack from kept entry", 32'(host_ack), 1);
        expect_eq("R9", "kept read data", host_rdata, 32'hCAFE_0001);
        expect_eq("R9", "no local request", 32'(loc_req), 0);
        @(posedge clk); #1;
        host_valid = 1'b0;

        // R7 + R9 write timeout then repeat
        @(posedge clk); #1;
        drive(1'b1, 32'h0000_0410, 1'b1, 1'b1, 4'h1, 32'h0000_005A);
        repeat (TO - 1) @(negedge clk);
        @(negedge clk);
        expect_eq("R7", "write retry", 32'(host_retry), 1);
        @(posedge clk); #1;
        host_valid = 1'b0; host_wdata = 32'h0;
        @(negedge clk);
        expect_eq("R8", "posted wdata", loc_wdata, 32'h0000_005A);
        expect_eq("R8", "posted write dir", 32'(loc_write), 1);
        @(posedge clk); #1;
        loc_rdy = 1'b1;
        @(posedge clk); #1;
        loc_rdy = 1'b0;
        drive(1'b1, 32'h0000_0410, 1'b1, 1'b1, 4'h1, 32'h0000_005A);
        @(negedge clk);
        expect_eq("R9", "write ack from kept entry", 32'(host_ack), 1);
        expect_eq("R9", "no local request for write", 32'(loc_req), 0);
        @(posedge clk); #1;
        host_valid = 1'b0;
        @(posedge clk); #1;
        drive(1'b1, 32'h0000_0410, 1'b1, 1'b1, 4'h1, 32'h0000_005A);
        @(negedge clk);
        expect_eq("R9", "entry used up: no ack", 32'(host_ack), 0);
        expect_eq("R9", "entry used up: fresh request", 32'(loc_req), 1);
        @(posedge clk); #1;
        host_valid = 1'b0;

        // R2 disabled window claims nothing
        @(posedge clk); #1;
        cfg_en = 4'b0111; loc_rdy = 1'b1;
        drive(1'b1, 32'h4000_0000, 1'b0, 1'b0, 4'hF, 0);
        @(negedge clk);
        expect_eq("R2", "disabled window miss", 32'(host_miss), 1);
        expect_eq("R2", "disabled window no ack", 32'(host_ack), 0);
        @(posedge clk); #1;
        host_valid = 1'b0; loc_rdy = 1'b0;
        @(negedge clk);
        expect_eq("R10", "idle: no response", 32'({host_ack, host_retry, host_miss}), 0);

        finish_run();
    end
endmodule